// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block is the master of an external bus on which one 32-bit set of lines carries first an address and then data. Each access runs in two tenures. In the address tenure the block drives the transfer size, the bank and the low address bits onto fixed fields of the shared lines. It marks them with a one-clock address latch enable and a one-clock transfer-start strobe, and attached devices latch them. In the following data tenure one of up to eight chip selects is asserted, together with output enable for reads and the read/write line. The shared lines then carry write data from the block, or are released so that the device can return read data.

Internally the block offers a simple request port. A request carries an address, write data, size, bank, direction and chip-select index, and is taken when the block is idle. Each chip select has its own wait-state count on a configuration input. The data tenure lasts one clock plus that count, unless the device pulls the acknowledge input low earlier. The access completes with a one-clock done pulse that presents the captured read data. All bus strobes are active low, and there is always at least one quiet clock between accesses.

Top module: `madbus_ctrl`

## Requirements
- R1: While reset is held and in the first idle clock after it, ale_n, ts_n, oe_n and rw_n are high, every cs_n bit is high, ad_oe and done are low and req_ready is high.
- R2: A request sampled with req_valid and req_ready high at a clock edge produces, in the next clock only, ale_n low, ts_n low and ad_oe high; req_ready is low from then until the access ends.
- R3: While ale_n is low, ad_out[30:28] equals the request size, ad_out[26:25] equals the bank, ad_out[24:0] equals request address bits 24..0, and ad_out[31] and ad_out[27] are zero.
- R4: In the data tenure exactly the cs_n bit selected by req_cs is low and ale_n and ts_n are high; no cs_n bit is low during the address tenure.
- R5: In a read data tenure oe_n is low, rw_n is high and ad_oe is low in every clock.
- R6: In a write data tenure oe_n is high, rw_n is low, ad_oe is high and ad_out equals the request write data in every clock.
- R7: With ack_n held high, cs_n stays low for exactly 1 + W clocks, where W is the 4-bit field cfg_wait[4*c+3:4*c] of the selected chip select c, sampled when the request is taken.
- R8: If ack_n is low at the clock edge ending data clock k (counted from 0), with k < W, the data tenure ends after k + 1 clocks.
- R9: For a read, rdata holds the value on ad_in at the clock edge that ends the data tenure; done is high for exactly one clock, the clock right after the data tenure, with rdata valid in that clock.
- R10: The clock after a data tenure has every strobe deasserted and req_ready low, so at least one idle clock separates a data tenure from the next address tenure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is taken at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 3 | Chip-select index |
| req_size | input | 3 | Transfer size code placed on the bus |
| req_bank | input | 2 | Bank code placed on the bus |
| req_addr | input | 32 | Request address (bits 24..0 go on the bus) |
| req_wdata | input | 32 | Write data |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Captured read data |
| cfg_wait | input | 32 | Wait-state count per chip select, 4 bits each |
| ad_out | output | 32 | Shared address/data lines, outgoing value |
| ad_oe | output | 1 | Drive enable for ad_out |
| ad_in | input | 32 | Shared address/data lines, incoming value |
| ale_n | output | 1 | Address latch enable, active low |
| ts_n | output | 1 | Transfer start, active low |
| cs_n | output | 8 | Chip selects, active low |
| oe_n | output | 1 | Output enable for reads, active low |
| rw_n | output | 1 | High for read, low for write |
| ack_n | input | 1 | Device acknowledge, active low |

## Verification
A request taken at edge N shows its address tenure in the clock after N. The data tenure starts one clock later and lasts 1 + W clocks, or k + 1 clocks when an acknowledge comes in data clock k. done and rdata follow in the clock after the last chip-select clock. The bench drives inputs and samples outputs on the falling edge. It walks the access clock by clock and compares each phase against the count it computes from the request and the wait settings. The bench model changes ad_in every data clock, so a capture made one edge early or late gives a wrong rdata.

// File: rtl/madbus_pkg.sv
package madbus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_GAP  = 2'd3
  } phase_t;

  localparam int unsigned BUS_W  = 32;
  localparam int unsigned SIZE_W = 3;
  localparam int unsigned BANK_W = 2;
  localparam int unsigned ALO_W  = 25;

  // Address tenure word: size at [30:28], bank at [26:25], addr[24:0] at [24:0].
  function automatic logic [BUS_W-1:0] pack_addr_tenure(
    input logic [SIZE_W-1:0] size,
    input logic [BANK_W-1:0] bank,
    input logic [BUS_W-1:0]  addr
  );
    logic [BUS_W-1:0] w;
    w        = '0;
    w[30:28] = size;
    w[26:25] = bank;
    w[24:0]  = addr[ALO_W-1:0];
    return w;
  endfunction

endpackage

// File: rtl/madbus_wait_ctr.sv
module madbus_wait_ctr #(
  parameter int unsigned WS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic [WS_W-1:0] ws,
  input  logic            ack_n,
  output logic            wait_expired,
  output logic            ack_seen,
  output logic            tenure_end
);

  logic [WS_W-1:0] cnt;

  function automatic logic reached(input logic [WS_W-1:0] c, input logic [WS_W-1:0] lim);
    return c == lim;
  endfunction

  assign wait_expired = active && reached(cnt, ws);
  assign ack_seen     = active && !ack_n;
  assign tenure_end   = wait_expired || ack_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (active && !tenure_end) cnt <= cnt + 1'b1;
    else                            cnt <= '0;
  end

endmodule

// File: rtl/madbus_seq.sv
module madbus_seq
  import madbus_pkg::*;
#(
  parameter int unsigned NCS  = 8,
  parameter int unsigned WS_W = 4,
  localparam int unsigned CS_W = $clog2(NCS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [CS_W-1:0]     req_cs,
  input  logic [SIZE_W-1:0]   req_size,
  input  logic [BANK_W-1:0]   req_bank,
  input  logic [BUS_W-1:0]    req_addr,
  input  logic [BUS_W-1:0]    req_wdata,
  input  logic [NCS*WS_W-1:0] cfg_wait,
  input  logic                tenure_end,
  input  logic [BUS_W-1:0]    ad_in,
  output phase_t              phase,
  output logic                accept,
  output logic                lat_write,
  output logic [CS_W-1:0]     lat_cs,
  output logic [SIZE_W-1:0]   lat_size,
  output logic [BANK_W-1:0]   lat_bank,
  output logic [BUS_W-1:0]    lat_addr,
  output logic [BUS_W-1:0]    lat_wdata,
  output logic [WS_W-1:0]     lat_ws,
  output logic [BUS_W-1:0]    rdata
);

  phase_t phase_nx;

  assign accept = req_valid && (phase == PH_IDLE);

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE: if (accept)     phase_nx = PH_ADDR;
      PH_ADDR:                 phase_nx = PH_DATA;
      PH_DATA: if (tenure_end) phase_nx = PH_GAP;
      PH_GAP:                  phase_nx = PH_IDLE;
      default:                 phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_write <= 1'b0;
      lat_cs    <= '0;
      lat_size  <= '0;
      lat_bank  <= '0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_ws    <= '0;
    end else if (accept) begin
      lat_write <= req_write;
      lat_cs    <= req_cs;
      lat_size  <= req_size;
      lat_bank  <= req_bank;
      lat_addr  <= req_addr;
      lat_wdata <= req_wdata;
      lat_ws    <= cfg_wait[req_cs*WS_W +: WS_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                           rdata <= '0;
    else if (phase == PH_DATA && tenure_end && !lat_write) rdata <= ad_in;
  end

endmodule

// File: rtl/madbus_pins.sv
module madbus_pins
  import madbus_pkg::*;
#(
  parameter int unsigned NCS = 8,
  localparam int unsigned CS_W = $clog2(NCS)
) (
  input  phase_t            phase,
  input  logic              lat_write,
  input  logic [CS_W-1:0]   lat_cs,
  input  logic [SIZE_W-1:0] lat_size,
  input  logic [BANK_W-1:0] lat_bank,
  input  logic [BUS_W-1:0]  lat_addr,
  input  logic [BUS_W-1:0]  lat_wdata,
  output logic [BUS_W-1:0]  ad_out,
  output logic              ad_oe,
  output logic              ale_n,
  output logic              ts_n,
  output logic [NCS-1:0]    cs_n,
  output logic              oe_n,
  output logic              rw_n
);

  logic in_addr, in_data;

  assign in_addr = (phase == PH_ADDR);
  assign in_data = (phase == PH_DATA);

  assign ale_n = !in_addr;
  assign ts_n  = !in_addr;
  assign oe_n  = !(in_data && !lat_write);
  assign rw_n  = !(in_data && lat_write);
  assign ad_oe = in_addr || (in_data && lat_write);

  always_comb begin
    if (in_addr)                      ad_out = pack_addr_tenure(lat_size, lat_bank, lat_addr);
    else if (in_data && lat_write)    ad_out = lat_wdata;
    else                              ad_out = '0;
  end

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_n[i] = !(in_data && (lat_cs == CS_W'(i)));
  end

endmodule

// File: rtl/madbus_ctrl.sv
module madbus_ctrl
  import madbus_pkg::*;
#(
  parameter int unsigned NCS  = 8,
  parameter int unsigned WS_W = 4,
  localparam int unsigned CS_W = $clog2(NCS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [CS_W-1:0]     req_cs,
  input  logic [2:0]          req_size,
  input  logic [1:0]          req_bank,
  input  logic [31:0]         req_addr,
  input  logic [31:0]         req_wdata,
  output logic                done,
  output logic [31:0]         rdata,
  input  logic [NCS*WS_W-1:0] cfg_wait,
  output logic [31:0]         ad_out,
  output logic                ad_oe,
  input  logic [31:0]         ad_in,
  output logic                ale_n,
  output logic                ts_n,
  output logic [NCS-1:0]      cs_n,
  output logic                oe_n,
  output logic                rw_n,
  input  logic                ack_n
);

  phase_t              phase;
  logic                accept;
  logic                data_phase;
  logic                wait_expired;
  logic                ack_seen;
  logic                tenure_end;
  logic                lat_write;
  logic [CS_W-1:0]     lat_cs;
  logic [SIZE_W-1:0]   lat_size;
  logic [BANK_W-1:0]   lat_bank;
  logic [BUS_W-1:0]    lat_addr;
  logic [BUS_W-1:0]    lat_wdata;
  logic [WS_W-1:0]     lat_ws;

  assign data_phase = (phase == PH_DATA);
  assign req_ready  = (phase == PH_IDLE);
  assign done       = (phase == PH_GAP);

  madbus_seq #(.NCS(NCS), .WS_W(WS_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_cs    (req_cs),
    .req_size  (req_size),
    .req_bank  (req_bank),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .cfg_wait  (cfg_wait),
    .tenure_end(tenure_end),
    .ad_in     (ad_in),
    .phase     (phase),
    .accept    (accept),
    .lat_write (lat_write),
    .lat_cs    (lat_cs),
    .lat_size  (lat_size),
    .lat_bank  (lat_bank),
    .lat_addr  (lat_addr),
    .lat_wdata (lat_wdata),
    .lat_ws    (lat_ws),
    .rdata     (rdata)
  );

  madbus_wait_ctr #(.WS_W(WS_W)) u_wait (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (data_phase),
    .ws          (lat_ws),
    .ack_n       (ack_n),
    .wait_expired(wait_expired),
    .ack_seen    (ack_seen),
    .tenure_end  (tenure_end)
  );

  madbus_pins #(.NCS(NCS)) u_pins (
    .phase     (phase),
    .lat_write (lat_write),
    .lat_cs    (lat_cs),
    .lat_size  (lat_size),
    .lat_bank  (lat_bank),
    .lat_addr  (lat_addr),
    .lat_wdata (lat_wdata),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .ale_n     (ale_n),
    .ts_n      (ts_n),
    .cs_n      (cs_n),
    .oe_n      (oe_n),
    .rw_n      (rw_n)
  );

endmodule

// File: rtl/madbus_ctrl_chk.sv
module madbus_ctrl_chk #(
  parameter int unsigned NCS  = 8,
  parameter int unsigned WS_W = 4,
  localparam int unsigned CS_W = $clog2(NCS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [CS_W-1:0]     req_cs,
  input logic [NCS*WS_W-1:0] cfg_wait,
  input logic                ale_n,
  input logic                ts_n,
  input logic [NCS-1:0]      cs_n,
  input logic                oe_n,
  input logic                ad_oe,
  input logic                ack_n,
  input logic                done,
  input logic                tenure_end
);

  logic [WS_W-1:0] exp_ws;
  logic [WS_W:0]   cs_cnt;
  logic            ack_hit;
  logic            cs_idle;

  assign cs_idle = &cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_ws  <= '0;
      cs_cnt  <= '0;
      ack_hit <= 1'b0;
    end else if (req_valid && req_ready) begin
      exp_ws  <= cfg_wait[req_cs*WS_W +: WS_W];
      cs_cnt  <= '0;
      ack_hit <= 1'b0;
    end else if (!cs_idle) begin
      cs_cnt  <= cs_cnt + 1'b1;
      if (!ack_n) ack_hit <= 1'b1;
    end
  end

  assert_accept_before_ale_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale_n) |-> $past(req_valid && req_ready));
  assert_ale_one_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_n |=> ale_n);
  assert_ts_with_ale_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ts_n |-> !ale_n && ad_oe);
  assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  assert_no_cs_in_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_n |-> cs_idle);
  assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !ad_oe && !cs_idle);
  assert_wait_len_R7_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_idle) |-> (ack_hit ? (cs_cnt <= {1'b0, exp_ws} + 1'b1)
                                : (cs_cnt == {1'b0, exp_ws} + 1'b1)));
  assert_done_follows_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tenure_end |=> done);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_gap_clock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_idle) |-> ale_n && !req_ready && done);

endmodule

bind madbus_ctrl madbus_ctrl_chk #(.NCS(NCS), .WS_W(WS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_cs    (req_cs),
  .cfg_wait  (cfg_wait),
  .ale_n     (ale_n),
  .ts_n      (ts_n),
  .cs_n      (cs_n),
  .oe_n      (oe_n),
  .ad_oe     (ad_oe),
  .ack_n     (ack_n),
  .done      (done),
  .tenure_end(tenure_end)
);

// File: tb/test_madbus_ctrl.sv
module test_madbus_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [2:0]  req_cs = '0;
  logic [2:0]  req_size = '0;
  logic [1:0]  req_bank = '0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        done;
  logic [31:0] rdata;
  logic [31:0] cfg_wait;
  logic [31:0] ad_out;
  logic        ad_oe;
  logic [31:0] ad_in = '0;
  logic        ale_n, ts_n, oe_n, rw_n;
  logic [7:0]  cs_n;
  logic        ack_n = 1'b1;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  madbus_ctrl i_madbus_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_cs(req_cs), .req_size(req_size), .req_bank(req_bank),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
    .cfg_wait(cfg_wait), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ale_n(ale_n), .ts_n(ts_n), .cs_n(cs_n), .oe_n(oe_n), .rw_n(rw_n), .ack_n(ack_n)
  );

  function automatic int ws_of(input int cs);
    return (cs == 0) ? 0 : 2 * cs + 1;
  endfunction

  // Wait settings: cs0 -> 0, cs c -> 2c+1, four bits each.
  always_comb begin
    cfg_wait = '0;
    for (int c = 0; c < 8; c++) cfg_wait[4*c +: 4] = 4'(ws_of(c));
  end

  function automatic logic [31:0] dev_data(input logic [31:0] a, input int cyc);
    return a ^ 32'h5A3C_0000 ^ 32'(cyc * 32'h0101);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // One access; ack_at < 0 means no acknowledge.
  task automatic access(input bit wr, input int cs, input int size, input int bank,
                        input logic [31:0] addr, input logic [31:0] wd, input int ack_at);
    int ws, exp_len, c;
    logic [31:0] exp_word, last_in;
    ws = ws_of(cs);
    exp_len = (ack_at >= 0 && ack_at < ws) ? ack_at + 1 : ws + 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_cs = 3'(cs);
    req_size = 3'(size); req_bank = 2'(bank); req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    // Address tenure
    chk("R2 strobes", {60'd0, ale_n, ts_n, ad_oe, req_ready}, {60'd0, 4'b0010});
    exp_word = '0;
    exp_word[30:28] = 3'(size);
    exp_word[26:25] = 2'(bank);
    exp_word[24:0]  = addr[24:0];
    chk("R3 fields", {32'd0, ad_out}, {32'd0, exp_word});
    chk("R4 no cs in addr", {56'd0, cs_n}, {56'd0, 8'hFF});
    @(negedge clk);
    c = 0;
    last_in = '0;
    while (cs_n != 8'hFF && c < 40) begin
      chk("R4 cs select", {54'd0, cs_n, ale_n, ts_n}, {54'd0, ~(8'd1 << cs), 2'b11});
      if (wr)
        chk("R6 write tenure", {29'd0, oe_n, rw_n, ad_oe, ad_out}, {29'd0, 3'b101, wd});
      else
        chk("R5 read tenure", {61'd0, oe_n, rw_n, ad_oe}, {61'd0, 3'b010});
      ad_in = dev_data(addr, c);
      last_in = ad_in;
      ack_n = (c == ack_at) ? 1'b0 : 1'b1;
      @(negedge clk);
      c++;
    end
    ack_n = 1'b1;
    ad_in = '0;
    chk((ack_at >= 0 && ack_at < ws) ? "R8 ack length" : "R7 wait length", 64'(c), 64'(exp_len));
    chk("R10 gap clock", {59'd0, ale_n, ts_n, oe_n, rw_n, req_ready}, {59'd0, 5'b11110});
    chk("R9 done high", {63'd0, done}, 64'd1);
    if (!wr) chk("R9 rdata capture", {32'd0, rdata}, {32'd0, last_in});
    @(negedge clk);
    chk("R9 done one clock", {62'd0, done, req_ready}, {62'd0, 2'b01});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset held", {51'd0, ale_n, ts_n, oe_n, rw_n, cs_n, ad_oe, done, req_ready},
        {51'd0, 4'b1111, 8'hFF, 3'b001});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {51'd0, ale_n, ts_n, oe_n, rw_n, cs_n, ad_oe, done, req_ready},
        {51'd0, 4'b1111, 8'hFF, 3'b001});
    // R3 sweep of all size and bank codes, high address bits set
    for (int s = 0; s < 8; s++)
      for (int b = 0; b < 4; b++)
        access(((s + b) % 2) == 1, (s + b) % 8, s, b,
               32'hFE00_0000 | ((32'(s * 4 + b) * 32'h0009_1A2B) & 32'h01FF_FFFF),
               32'hC0DE_0000 + 32'(s * 16 + b), -1);
    // R7 wait counts per chip select, read and write
    for (int c = 0; c < 8; c++) begin
      access(1'b0, c, 2, 1, 32'h0012_3400 + 32'(c), 32'h0, -1);
      access(1'b1, c, 5, 2, 32'h01AB_CD00 + 32'(c), 32'hA5A5_0000 + 32'(c), -1);
    end
    // R8 acknowledge at each data clock of cs4 (W = 9)
    for (int k = 0; k <= 9; k++) begin
      access(1'b0, 4, 1, 3, 32'h0000_4440 + 32'(k), 32'h0, k);
      access(1'b1, 4, 1, 3, 32'h0000_5550 + 32'(k), 32'h1234_0000 + 32'(k), k);
    end
    // acknowledge on a zero-wait chip select
    access(1'b0, 0, 7, 0, 32'h01FF_FFFF, 32'h0, 0);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      summary();
    end
  end

endmodule